// File: doc/BRIEF.md
# Bidirectional Saturating Arithmetic Shifter

This block is a purely combinational shifter for signed fixed-point words. It takes a data word, a signed shift count and a two-bit mode, and returns the shifted word in the same evaluation. A positive count shifts left. When the result would not fit in the signed word, it clamps to the largest or smallest representable value instead of wrapping. A negative count shifts right by the count's magnitude, with sign fill.

There are two lane widths: a 16-bit short lane and a 32-bit long lane. Each lane has a plain right shift and a rounding right shift. The rounding variant adds back the last bit shifted out, so a DSP datapath can rescale a value with round-half-up behaviour. The block has no state and no FSM; clock and reset exist only in the bench.

Top module: `sat_shifter`

## Requirements
- R1: `mode_sel[1]` selects the lane: 0 is the short lane, 1 is the long lane. `mode_sel[0]` set turns on rounding for right shifts. The short lane reads only `din[15:0]` and returns its 16-bit result sign-extended onto all 32 bits of `dout`.
- R2: With a positive count, a left shift whose result fits in the lane's signed width returns the input multiplied by 2 to the power of the count.
- R3: In the short lane, a left shift that overflows 16 signed bits returns 0x7FFF for a non-negative input and 0x8000 for a negative input. Any count of 16 or more with a nonzero input saturates. A zero input stays zero.
- R4: A negative count shifts right arithmetically by its magnitude, including the count -32768, whose magnitude is 32768.
- R5: In the short lane without rounding, a right shift of 15 or more returns -1 for a negative input and 0 otherwise.
- R6: In the long lane, a left shift that overflows 32 signed bits returns 0x7FFFFFFF for a non-negative input or 0x80000000 for a negative input. Any count of 32 or more with a nonzero input saturates.
- R7: In the long lane without rounding, a right shift of 31 or more returns -1 for a negative input and 0 otherwise.
- R8: With rounding on, a right shift by magnitude m returns the arithmetic shift result plus input bit m-1.
- R9: With rounding on, a right shift returns 0 when the magnitude exceeds 15 in the short lane or 31 in the long lane. At exactly 15 or 31 it still rounds.
- R10: A zero count returns the lane's input unchanged in every mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| din | input | 32 | Data word; the short lane uses bits 15:0 |
| shift_cnt | input | 16 | Signed two's-complement shift count; positive is left, negative is right |
| mode_sel | input | 2 | Bit 1 selects the long lane; bit 0 enables rounding on right shifts |
| dout | output | 32 | Shifted, saturated or rounded result; short results are sign-extended |

## Verification
The in-line checks assume every input bit is a known 0 or 1. They also assume all four `mode_sel` codes are legal, so no input combination is treated as forbidden. The stimulus therefore always drives fully defined words from reset onwards. It sweeps counts from -40 to +40 against boundary words of both lanes, and adds the extreme counts -32768 and 32767. Random words are mixed in with random modes and counts in the same window.

// File: rtl/sat_shift_pkg.sv
package sat_shift_pkg;

    localparam int SHORT_W = 16;
    localparam int LONG_W  = 32;
    localparam int CNT_W   = 16;

    // bit 1: long lane, bit 0: rounding on right shifts
    typedef enum logic [1:0] {
        MODE_SHORT     = 2'b00,
        MODE_SHORT_RND = 2'b01,
        MODE_LONG      = 2'b10,
        MODE_LONG_RND  = 2'b11
    } shift_mode_e;

    function automatic logic mode_is_long(input logic [1:0] m);
        return m[1];
    endfunction

    function automatic logic mode_is_rnd(input logic [1:0] m);
        return m[0];
    endfunction

endpackage

// File: rtl/sat_left_unit.sv
module sat_left_unit #(
    parameter int W  = 16,
    parameter int AW = 17
) (
    input  logic [W-1:0]  val,
    input  logic [AW-1:0] amt,
    output logic [W-1:0]  res,
    output logic          clipped
);
    localparam int XW = 2 * W;
    localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

    logic [XW-1:0] wide;
    logic [W:0]    top_bits;

    always_comb begin
        wide     = {{W{val[W-1]}}, val} << amt;
        top_bits = wide[XW-1:W-1];
        if (amt >= AW'(W)) begin
            clipped = |val;
        end else begin
            clipped = !((&top_bits) || (~|top_bits));
        end
        res = clipped ? (val[W-1] ? MINV : MAXV) : wide[W-1:0];
    end

    // R3 / R6: a clipped result carries the input's sign at full scale
    always_comb begin
        if (clipped) begin
            a_r3_clip_sign: assert (res == (val[W-1] ? MINV : MAXV))
                else $error("clipped result has wrong rail");
        end
    end

endmodule

// File: rtl/sat_right_unit.sv
module sat_right_unit #(
    parameter int W  = 16,
    parameter int AW = 17
) (
    input  logic [W-1:0]  val,
    input  logic [AW-1:0] amt,
    input  logic          rnd,
    output logic [W-1:0]  res
);
    localparam int SW = $clog2(W);

    logic [SW-1:0] amt_c;
    logic          too_far;
    logic [W-1:0]  shifted;
    logic          rbit;

    always_comb begin
        too_far = amt > AW'(W-1);
        amt_c   = too_far ? SW'(W-1) : amt[SW-1:0];
        shifted = $signed(val) >>> amt_c;
        rbit    = (amt_c != '0) ? val[amt_c - 1'b1] : 1'b0;
        if (rnd) begin
            res = too_far ? '0 : (shifted + {{(W-1){1'b0}}, rbit});
        end else begin
            res = shifted;
        end
    end

    // R5 / R7: plain shifts at or past W-1 leave only sign copies
    always_comb begin
        if (!rnd && amt >= AW'(W-1)) begin
            a_r5_sign_fill: assert (res == {W{val[W-1]}})
                else $error("long right shift did not collapse to sign");
        end
    end

    // R9: rounded shifts past W-1 return zero
    always_comb begin
        if (rnd && too_far) begin
            a_r9_round_zero: assert (res == '0)
                else $error("rounded far shift not zero");
        end
    end

endmodule

// File: rtl/shift_lane.sv
module shift_lane #(
    parameter int W  = 16,
    parameter int CW = 16
) (
    input  logic [W-1:0]  val,
    input  logic [CW-1:0] cnt,
    input  logic          rnd,
    output logic [W-1:0]  res
);
    localparam int AW = CW + 1;

    logic [AW-1:0] cnt_ext;
    logic [AW-1:0] mag;
    logic          go_right;
    logic [W-1:0]  left_res;
    logic [W-1:0]  right_res;
    logic          left_clip;

    always_comb begin
        cnt_ext  = {cnt[CW-1], cnt};
        go_right = cnt[CW-1];
        mag      = go_right ? (~cnt_ext + 1'b1) : cnt_ext;
    end

    sat_left_unit #(.W(W), .AW(AW)) u_left (
        .val     (val),
        .amt     (mag),
        .res     (left_res),
        .clipped (left_clip)
    );

    sat_right_unit #(.W(W), .AW(AW)) u_right (
        .val (val),
        .amt (mag),
        .rnd (rnd),
        .res (right_res)
    );

    always_comb begin
        res = go_right ? right_res : left_res;
    end

    // R10: zero count is a pass-through
    always_comb begin
        if (cnt == '0) begin
            a_r10_zero_pass: assert (res == val)
                else $error("zero count altered data");
        end
    end

    // R2: an unclipped left shift keeps the low bits cleared
    always_comb begin
        if (!go_right && !left_clip && mag != '0 && mag < AW'(W)) begin
            a_r2_low_zero: assert (res[0] == 1'b0)
                else $error("left shift left a set low bit");
        end
    end

endmodule

// File: rtl/sat_shifter.sv
module sat_shifter
    import sat_shift_pkg::*;
#(
    parameter int S_W = SHORT_W,
    parameter int L_W = LONG_W,
    parameter int C_W = CNT_W
) (
    input  logic [L_W-1:0] din,
    input  logic [C_W-1:0] shift_cnt,
    input  logic [1:0]     mode_sel,
    output logic [L_W-1:0] dout
);
    localparam int NLANE = 2;

    logic [L_W-1:0] lane_out [NLANE];

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        localparam int LW = (g == 0) ? S_W : L_W;
        logic [LW-1:0] r;

        shift_lane #(.W(LW), .CW(C_W)) u_lane (
            .val (din[LW-1:0]),
            .cnt (shift_cnt),
            .rnd (mode_is_rnd(mode_sel)),
            .res (r)
        );

        if (LW < L_W) begin : g_ext
            assign lane_out[g] = {{(L_W-LW){r[LW-1]}}, r};
        end else begin : g_full
            assign lane_out[g] = r;
        end
    end

    always_comb begin
        dout = mode_is_long(mode_sel) ? lane_out[1] : lane_out[0];
    end

    // R1: short results are sign-extended across the full word
    always_comb begin
        if (!mode_is_long(mode_sel)) begin
            a_r1_short_sext: assert (dout[L_W-1:S_W-1] == '0 || &dout[L_W-1:S_W-1])
                else $error("short result not sign-extended");
        end
    end

endmodule

// File: tb/tb_sat_shifter.sv
module tb_sat_shifter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] din;
    logic [15:0] shift_cnt;
    logic [1:0]  mode_sel;
    logic [31:0] dout;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #2.5 clk = ~clk;

    sat_shifter dut (
        .din       (din),
        .shift_cnt (shift_cnt),
        .mode_sel  (mode_sel),
        .dout      (dout)
    );

    function automatic logic [31:0] model(input logic [1:0] md, input logic [31:0] d,
                                          input int cnt, output string tag);
        int     w;
        int     m;
        longint v;
        longint r;
        longint mx;
        longint mn;
        w  = md[1] ? 32 : 16;
        v  = md[1] ? longint'($signed(d)) : longint'($signed(d[15:0]));
        mx = (longint'(1) <<< (w - 1)) - 1;
        mn = -mx - 1;
        if (cnt == 0) begin
            r = v; tag = "R10";
        end else if (cnt > 0) begin
            if (v == 0) begin
                r = 0; tag = "R2";
            end else if (cnt >= w) begin
                r = (v < 0) ? mn : mx; tag = md[1] ? "R6" : "R3";
            end else begin
                r = v * (longint'(1) <<< cnt);
                tag = "R2";
                if (r > mx) begin r = mx; tag = md[1] ? "R6" : "R3"; end
                else if (r < mn) begin r = mn; tag = md[1] ? "R6" : "R3"; end
            end
        end else begin
            m = -cnt;
            if (md[0]) begin
                if (m > w - 1) begin r = 0; tag = "R9"; end
                else begin r = (v >>> m) + ((v >> (m - 1)) & 1); tag = "R8"; end
            end else begin
                if (m >= w - 1) begin r = (v < 0) ? -1 : 0; tag = md[1] ? "R7" : "R5"; end
                else begin r = v >>> m; tag = "R4"; end
            end
        end
        return r[31:0];
    endfunction

    task automatic check(input logic [1:0] md, input logic [31:0] d, input int cnt);
        logic [31:0] exp;
        string       tag;
        @(negedge clk);
        din       = d;
        shift_cnt = cnt[15:0];
        mode_sel  = md;
        #1;
        exp = model(md, d, cnt, tag);
        n_tests++;
        if (dout !== exp) begin
            n_fail++;
            $display("FAIL %s mode=%0d din=%h cnt=%0d got=%h exp=%h",
                     tag, md, d, cnt, dout, exp);
        end
    endtask

    task automatic check_fixed(input string tag, input logic [1:0] md, input logic [31:0] d,
                               input int cnt, input logic [31:0] exp);
        @(negedge clk);
        din       = d;
        shift_cnt = cnt[15:0];
        mode_sel  = md;
        #1;
        n_tests++;
        if (dout !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h exp=%h", tag, dout, exp);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : stim
        logic [31:0] corners [12];
        int unused_seed;
        corners = '{32'h0, 32'h1, 32'hFFFFFFFF, 32'h00007FFF, 32'h00008000, 32'h00004000,
                    32'h7FFFFFFF, 32'h80000000, 32'h40000000, 32'h12345678, 32'hC0000000,
                    32'hFFFFC001};
        din = '0; shift_cnt = '0; mode_sel = '0;
        repeat (4) @(posedge clk);
        rst_n = 1'b1;

        // reset-time idle value: zero in, zero out (R10)
        check_fixed("R10", 2'b00, 32'h0, 0, 32'h0);
        // R1: upper bits ignored in short lane, result sign-extended
        check_fixed("R1", 2'b00, 32'hABCD0005, 1, 32'h0000000A);
        check_fixed("R1", 2'b00, 32'h0000C000, 0, 32'hFFFFC000);
        check_fixed("R1", 2'b10, 32'hABCD0005, 0, 32'hABCD0005);
        // R3 / R6 rails
        check_fixed("R3", 2'b00, 32'h00004000, 1, 32'h00007FFF);
        check_fixed("R3", 2'b00, 32'h0000FFFF, 16, 32'hFFFF8000);
        check_fixed("R6", 2'b10, 32'h00000001, 32, 32'h7FFFFFFF);
        // R9 boundary: exactly 15 still rounds
        check_fixed("R9", 2'b01, 32'h00004000, -15, 32'h00000001);
        check_fixed("R9", 2'b01, 32'h00004000, -16, 32'h00000000);
        // R4 extreme magnitude
        check_fixed("R4", 2'b10, 32'h80000000, -32768, 32'hFFFFFFFF);

        for (int md = 0; md < 4; md++) begin
            for (int c = -40; c <= 40; c++) begin
                for (int k = 0; k < 12; k++) begin
                    check(2'(md), corners[k], c);
                end
            end
            check(2'(md), 32'h00001234, 32767);
            check(2'(md), 32'hFFFF8765, -32768);
        end

        unused_seed = $urandom(32'd2024);
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] d;
            int          c;
            d = $urandom();
            if (i % 3 == 0) d = d >> ($urandom() % 32);
            if (i % 5 == 0) d = ~d;
            c = int'($urandom_range(80)) - 40;
            check(2'($urandom_range(3)), d, c);
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule